// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This block gathers eight interrupt request lines, holds each in a request register, and decides which one the CPU should see next. Priority is fixed, with line 0 highest. The block raises a single interrupt output when a pending, unmasked request outranks everything already being serviced. When the CPU answers with a one-cycle acknowledge pulse, the block:

- moves the winning line into service;
- drops its latched request;
- returns an 8-bit vector one cycle later.

Software later retires the serviced line with a non-specific end-of-service command.

Software configures the block through a byte-wide register port with two addresses, command (0) and data (1). A third address (2) holds the per-line trigger selection. The configuration is a short sequence of setup words. After the sequence completes, data writes load the mask, and command writes issue end-of-service or choose which register a command-address read returns. Two instances can be chained. The master learns from its setup words which of its lines carry a slave. It steers the acknowledge to that slave over a 3-bit cascade bus. The slave compares the bus against its own 3-bit identity and then supplies the vector itself. An acknowledge that finds no surviving request returns the line-7 vector without marking line 7 in service.

Top module: `casc_intc`

## Requirements
- R1: After reset the interrupt output and the vector-valid strobe are low. The mask (address 1), the trigger register (address 2) and the command-address read are all 0x00, and the block ignores requests until it has been set up.
- R2: A command write with bit 4 set starts setup, and its bit 0 says whether a mode word follows. The next data writes are taken in order:
  - the vector base;
  - the cascade word;
  - the mode word, only when bit 0 requested it.

  Every data write after that loads the mask.
- R3: The vector on `vec_out` is the base word with its low three bits replaced by the line number. It appears with `vec_vld` high for one cycle, in the cycle after the acknowledge pulse.
- R4: Among pending unmasked lines the lowest number wins the acknowledge, and that acknowledge sets exactly one in-service bit.
- R5: `int_req` is high only when the best pending unmasked line has a lower number than every in-service line.
- R6: A mask bit of 1 keeps its line from raising `int_req`. A request latched while the line is masked is kept and is served once the line is unmasked.
- R7: Trigger register bit 1 means level: that line's request follows its input. Bit 0 means edge: a rising input sets the request, the acknowledge clears it, and an input that stays high does not set it again.
- R8: Command write 0x20 clears the in-service bit of the highest-priority line (the lowest-numbered in-service line).
- R9: A command write with bit 4 at 0 and bit 3 at 1 selects what a command-address read returns. Low bits 11 (0x0B) select the in-service register and 10 (0x0A) select the request register. The request register is the default.
- R10: An acknowledge with no pending unmasked request returns base+7 and leaves the in-service register unchanged.
- R11: A setup-start write clears the mask, the in-service bits and the latched edge requests, and resets the read selection to the request register.
- R12: In a master (`slave_mode`=0), cascade-word bit n marks line n as carrying a slave. When such a line wins an acknowledge, the master marks it in service and, during the acknowledge cycle, drives `cas_sel_out` high and the line number on `cas_out`. The master gives no vector of its own.
- R13: In a slave (`slave_mode`=1), cascade-word bits 2:0 are its identity. The slave takes an acknowledge only when `cas_sel_in` is high and `cas_in` matches that identity. It ignores every other acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | 1 = slave in a cascade, 0 = master or standalone |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 command, 1 data, 2 trigger select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Interrupt request lines, synchronous to clk |
| int_req | output | 1 | Interrupt request to the CPU |
| ack | input | 1 | One-cycle acknowledge pulse |
| cas_in | input | 3 | Cascade bus from the master (slave use) |
| cas_sel_in | input | 1 | Cascade bus valid from the master (slave use) |
| cas_out | output | 3 | Cascade line number driven by the master |
| cas_sel_out | output | 1 | Cascade bus valid, high in a master's acknowledge cycle for a slave line |
| vec_out | output | 8 | Returned vector |
| vec_vld | output | 1 | One-cycle strobe marking `vec_out` valid |

## Verification
The bench applies several request patterns, each separating one rule from the others:
- A single edge request separates the base-plus-line vector from any priority effect.
- Two lines raised together, then a higher line raised while a lower one is in service, separate fixed priority from the nesting rule and show which in-service bit the end-of-service command clears.
- A request that is masked and then unmasked checks that masking holds a request rather than drops it.
- A level line that falls just before the acknowledge separates the spurious path from a normal one. The same line held high across end-of-service separates level behaviour from edge behaviour.
- A master and slave pair runs two cases: a master-local line, which the slave must ignore, and a slave line, which must be routed over the cascade bus.

// File: rtl/casc_intc_pkg.sv
package casc_intc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_BASE = 3'd1,
    ST_CASC = 3'd2,
    ST_MODE = 3'd3,
    ST_RUN  = 3'd4
  } setup_st_e;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_TRIG = 2'd2;

  localparam logic [2:0] EOI_NONSPEC = 3'b001;

endpackage

// File: rtl/casc_intc_req.sv
module casc_intc_req #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] lvl_sel,
  input  logic          clr_all,
  input  logic [NL-1:0] ack_clr,
  output logic [NL-1:0] irr
);

  logic [NL-1:0] irq_q;
  logic [NL-1:0] latch_q;
  logic [NL-1:0] latch_d;

  for (genvar i = 0; i < NL; i++) begin : g_line
    logic rise;
    assign rise = irq_in[i] & ~irq_q[i];

    always_comb begin
      if (clr_all || lvl_sel[i]) begin
        latch_d[i] = 1'b0;
      end else begin
        latch_d[i] = (latch_q[i] & ~ack_clr[i]) | rise;
      end
    end

    assign irr[i] = lvl_sel[i] ? irq_q[i] : latch_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= '0;
      latch_q <= '0;
    end else begin
      irq_q   <= irq_in;
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/casc_intc_prio.sv
module casc_intc_prio #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic [NL-1:0] irr,
  input  logic [NL-1:0] imr,
  input  logic [NL-1:0] isr,
  output logic [IW-1:0] win_idx,
  output logic          win_vld,
  output logic [IW-1:0] top_idx,
  output logic          top_vld
);

  logic [NL-1:0] pend;
  logic [IW-1:0] p_idx;
  logic          p_any;

  assign pend = irr & ~imr;

  always_comb begin
    p_idx = '0;
    p_any = 1'b0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (pend[i]) begin
        p_idx = IW'(i);
        p_any = 1'b1;
      end
    end
  end

  always_comb begin
    top_idx = '0;
    top_vld = 1'b0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (isr[i]) begin
        top_idx = IW'(i);
        top_vld = 1'b1;
      end
    end
  end

  assign win_idx = p_idx;
  assign win_vld = p_any && (!top_vld || (p_idx < top_idx));

endmodule

// File: rtl/casc_intc_ctrl.sv
module casc_intc_ctrl
  import casc_intc_pkg::*;
#(
  parameter int NL = 8,
  localparam int IW = $clog2(NL),
  localparam int BW = NL - IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [NL-1:0] bus_wdata,
  input  logic          ack,
  input  logic [IW-1:0] cas_in,
  input  logic          cas_sel_in,
  input  logic [IW-1:0] win_idx,
  input  logic          win_vld,
  input  logic [IW-1:0] top_idx,
  input  logic          top_vld,
  output logic [NL-1:0] imr,
  output logic [NL-1:0] isr,
  output logic [NL-1:0] lvl,
  output logic          rd_isr,
  output logic          run,
  output logic          clr_all,
  output logic [NL-1:0] ack_clr,
  output logic          cas_sel_out,
  output logic [NL-1:0] vec_out,
  output logic          vec_vld
);

  setup_st_e     st_q, st_d;
  logic [NL-1:0] imr_q, imr_d;
  logic [NL-1:0] isr_q, isr_d;
  logic [NL-1:0] lvl_q, lvl_d;
  logic [BW-1:0] base_q, base_d;
  logic [NL-1:0] map_q, map_d;
  logic          need4_q, need4_d;
  logic          rdisr_q, rdisr_d;
  logic [NL-1:0] vec_q, vec_d;
  logic          vld_q, vld_d;

  logic cmd_wr, data_wr, trig_wr, start_wr;
  logic ack_take, casc_hit;
  logic [IW-1:0] my_id;

  assign cmd_wr   = bus_wr && (bus_addr == A_CMD);
  assign data_wr  = bus_wr && (bus_addr == A_DATA);
  assign trig_wr  = bus_wr && (bus_addr == A_TRIG);
  assign start_wr = cmd_wr && bus_wdata[4];
  assign run      = (st_q == ST_RUN);
  assign my_id    = map_q[IW-1:0];

  assign ack_take = ack && run &&
                    (!slave_mode || (cas_sel_in && (cas_in == my_id)));
  assign casc_hit = !slave_mode && win_vld && map_q[win_idx];
  assign cas_sel_out = ack && run && casc_hit;

  always_comb begin
    st_d    = st_q;
    imr_d   = imr_q;
    isr_d   = isr_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    map_d   = map_q;
    need4_d = need4_q;
    rdisr_d = rdisr_q;
    vec_d   = vec_q;
    vld_d   = 1'b0;
    clr_all = 1'b0;
    ack_clr = '0;

    if (trig_wr) begin
      lvl_d = bus_wdata;
    end

    if (start_wr) begin
      st_d    = ST_BASE;
      need4_d = bus_wdata[0];
      imr_d   = '0;
      isr_d   = '0;
      rdisr_d = 1'b0;
      clr_all = 1'b1;
    end else begin
      if (cmd_wr && run) begin
        if (bus_wdata[3]) begin
          if (bus_wdata[1]) begin
            rdisr_d = bus_wdata[0];
          end
        end else if ((bus_wdata[7:5] == EOI_NONSPEC) && top_vld) begin
          isr_d[top_idx] = 1'b0;
        end
      end

      if (data_wr) begin
        unique case (st_q)
          ST_BASE: begin
            base_d = bus_wdata[NL-1:IW];
            st_d   = ST_CASC;
          end
          ST_CASC: begin
            map_d = bus_wdata;
            st_d  = need4_q ? ST_MODE : ST_RUN;
          end
          ST_MODE: st_d  = ST_RUN;
          ST_RUN:  imr_d = bus_wdata;
          default: st_d  = st_q;
        endcase
      end

      if (ack_take) begin
        if (win_vld) begin
          isr_d[win_idx]   = 1'b1;
          ack_clr[win_idx] = 1'b1;
          if (!casc_hit) begin
            vec_d = {base_q, win_idx};
            vld_d = 1'b1;
          end
        end else begin
          vec_d = {base_q, IW'(NL - 1)};
          vld_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      imr_q   <= '0;
      isr_q   <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      map_q   <= '0;
      need4_q <= 1'b0;
      rdisr_q <= 1'b0;
      vec_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      imr_q   <= imr_d;
      isr_q   <= isr_d;
      lvl_q   <= lvl_d;
      base_q  <= base_d;
      map_q   <= map_d;
      need4_q <= need4_d;
      rdisr_q <= rdisr_d;
      vld_q   <= vld_d;
      if (vld_d) begin
        vec_q <= vec_d;
      end
    end
  end

  assign imr     = imr_q;
  assign isr     = isr_q;
  assign lvl     = lvl_q;
  assign rd_isr  = rdisr_q;
  assign vec_out = vec_q;
  assign vec_vld = vld_q;

endmodule

// File: rtl/casc_intc.sv
module casc_intc #(
  parameter int NL = 8,
  localparam int IW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [NL-1:0] bus_wdata,
  output logic [NL-1:0] bus_rdata,
  input  logic [NL-1:0] irq_in,
  output logic          int_req,
  input  logic          ack,
  input  logic [IW-1:0] cas_in,
  input  logic          cas_sel_in,
  output logic [IW-1:0] cas_out,
  output logic          cas_sel_out,
  output logic [NL-1:0] vec_out,
  output logic          vec_vld
);

  logic [NL-1:0] irr_w, imr_w, isr_w, lvl_w, ack_clr_w;
  logic [IW-1:0] win_idx_w, top_idx_w;
  logic          win_vld_w, top_vld_w, rd_isr_w, run_w, clr_all_w;

  casc_intc_req #(.NL(NL)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .lvl_sel (lvl_w),
    .clr_all (clr_all_w),
    .ack_clr (ack_clr_w),
    .irr     (irr_w)
  );

  casc_intc_prio #(.NL(NL)) u_prio (
    .irr     (irr_w),
    .imr     (imr_w),
    .isr     (isr_w),
    .win_idx (win_idx_w),
    .win_vld (win_vld_w),
    .top_idx (top_idx_w),
    .top_vld (top_vld_w)
  );

  casc_intc_ctrl #(.NL(NL)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .slave_mode  (slave_mode),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ack         (ack),
    .cas_in      (cas_in),
    .cas_sel_in  (cas_sel_in),
    .win_idx     (win_idx_w),
    .win_vld     (win_vld_w),
    .top_idx     (top_idx_w),
    .top_vld     (top_vld_w),
    .imr         (imr_w),
    .isr         (isr_w),
    .lvl         (lvl_w),
    .rd_isr      (rd_isr_w),
    .run         (run_w),
    .clr_all     (clr_all_w),
    .ack_clr     (ack_clr_w),
    .cas_sel_out (cas_sel_out),
    .vec_out     (vec_out),
    .vec_vld     (vec_vld)
  );

  assign int_req = run_w && win_vld_w;
  assign cas_out = cas_sel_out ? win_idx_w : '0;

  always_comb begin
    unique case (bus_addr)
      2'd0:    bus_rdata = rd_isr_w ? isr_w : irr_w;
      2'd1:    bus_rdata = imr_w;
      2'd2:    bus_rdata = lvl_w;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/casc_intc_chk.sv
module casc_intc_chk #(
  parameter int NL = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_mode,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [NL-1:0] bus_wdata,
  input logic          ack,
  input logic          cas_sel_in,
  input logic          int_req,
  input logic          cas_sel_out,
  input logic          vec_vld,
  input logic [NL-1:0] irr,
  input logic [NL-1:0] imr,
  input logic [NL-1:0] isr,
  input logic          run
);

  p_vec_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> $past(ack));

  p_one_isr_per_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !slave_mode && !bus_wr)
    |=> ($countones(isr) == $past($countones(isr)) + 1));

  p_int_only_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> run);

  p_int_needs_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~imr) != '0));

  p_eoi_clears_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata == 8'h20 && run && isr != '0 && !ack)
    |=> ($countones(isr) + 1 == $past($countones(isr))));

  p_spurious_keeps_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && run && !int_req && !slave_mode && !bus_wr) |=> (isr == $past(isr)));

  p_cascade_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cas_sel_out |-> (ack && !slave_mode));

  p_slave_ignores_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && ack && !cas_sel_in && !bus_wr) |=> (!vec_vld && isr == $past(isr)));

endmodule

bind casc_intc casc_intc_chk #(.NL(NL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slave_mode  (slave_mode),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .ack         (ack),
  .cas_sel_in  (cas_sel_in),
  .int_req     (int_req),
  .cas_sel_out (cas_sel_out),
  .vec_vld     (vec_vld),
  .irr         (irr_w),
  .imr         (imr_w),
  .isr         (isr_w),
  .run         (run_w)
);

// File: tb/casc_intc_bench.sv
module casc_intc_bench;

  logic clk;
  logic rst_n;

  logic       m_wr, s_wr;
  logic [1:0] m_addr, s_addr;
  logic [7:0] m_wdata, s_wdata, m_rdata, s_rdata;
  logic [7:0] m_irq, s_irq, m_irq_eff;
  logic       ack, cascade_on;
  logic       m_int, s_int, m_cas_sel, s_cas_sel;
  logic [2:0] m_cas, s_cas;
  logic [7:0] m_vec, s_vec;
  logic       m_vld, s_vld;

  int n_chk;
  int n_fail;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign m_irq_eff = cascade_on ? {m_irq[7:3], s_int, m_irq[1:0]} : m_irq;

  casc_intc u_casc_intc (
    .clk(clk), .rst_n(rst_n), .slave_mode(1'b0),
    .bus_wr(m_wr), .bus_addr(m_addr), .bus_wdata(m_wdata), .bus_rdata(m_rdata),
    .irq_in(m_irq_eff), .int_req(m_int), .ack(ack),
    .cas_in(3'd0), .cas_sel_in(1'b0), .cas_out(m_cas), .cas_sel_out(m_cas_sel),
    .vec_out(m_vec), .vec_vld(m_vld)
  );

  casc_intc u_casc_intc_slv (
    .clk(clk), .rst_n(rst_n), .slave_mode(1'b1),
    .bus_wr(s_wr), .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_rdata(s_rdata),
    .irq_in(s_irq), .int_req(s_int), .ack(ack),
    .cas_in(m_cas), .cas_sel_in(m_cas_sel), .cas_out(s_cas), .cas_sel_out(s_cas_sel),
    .vec_out(s_vec), .vec_vld(s_vld)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", what, act, exp);
    end
  endtask

  // monitor: pops the expected vector whenever either device strobes one
  always @(negedge clk) begin
    if (rst_n && (m_vld || s_vld)) begin
      n_chk++;
      if (m_vld && s_vld) begin
        n_fail++;
        $display("FAIL R13: both devices strobed a vector, got %02h/%02h expected one", m_vec, s_vec);
      end else if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected vector got %02h expected none", m_vld ? m_vec : s_vec);
      end else begin
        logic [7:0] e;
        string t;
        logic [7:0] got;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        got = m_vld ? m_vec : s_vec;
        if (got !== e) begin
          n_fail++;
          $display("FAIL %s: vector got %02h expected %02h", t, got, e);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_m(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    m_addr = a; m_wdata = d; m_wr = 1'b1;
    @(negedge clk);
    m_wr = 1'b0;
  endtask

  task automatic wr_s(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    s_addr = a; s_wdata = d; s_wr = 1'b1;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic rd_m(input logic [1:0] a, input logic [7:0] e, input string what);
    @(negedge clk);
    m_addr = a;
    #1;
    chk(m_rdata, e, what);
  endtask

  task automatic rd_s(input logic [1:0] a, input logic [7:0] e, input string what);
    @(negedge clk);
    s_addr = a;
    #1;
    chk(s_rdata, e, what);
  endtask

  task automatic do_ack(input logic [7:0] e, input bit cas_chk, input string what);
    exp_q.push_back(e);
    tag_q.push_back(what);
    @(negedge clk);
    ack = 1'b1;
    #1;
    if (cas_chk) begin
      chk({7'd0, m_cas_sel}, 8'h01, "R12 cascade select during acknowledge");
      chk({5'd0, m_cas}, 8'h02, "R12 cascade line number");
    end
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_int(input logic exp, input string what);
    #1;
    chk({7'd0, m_int}, {7'd0, exp}, what);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; ack = 1'b0; cascade_on = 1'b0;
    m_wr = 1'b0; m_addr = 2'd0; m_wdata = 8'h00; m_irq = 8'h00;
    s_wr = 1'b0; s_addr = 2'd0; s_wdata = 8'h00; s_irq = 8'h00;
    wait_cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    chk_int(1'b0, "R1 int_req after reset");
    chk({7'd0, m_vld}, 8'h00, "R1 vec_vld after reset");
    rd_m(2'd1, 8'h00, "R1 mask after reset");
    rd_m(2'd2, 8'h00, "R1 trigger register after reset");
    rd_m(2'd0, 8'h00, "R1 command read after reset");
    m_irq[4] = 1'b1;
    wait_cyc(3);
    chk_int(1'b0, "R1 request ignored before setup");
    m_irq[4] = 1'b0;

    // R2 setup with the mode word
    wr_m(2'd0, 8'h11);
    wr_m(2'd1, 8'h08);
    wr_m(2'd1, 8'h00);
    wr_m(2'd1, 8'h01);
    rd_m(2'd1, 8'h00, "R2 mode word not loaded as mask");
    wr_m(2'd1, 8'hF0);
    rd_m(2'd1, 8'hF0, "R2 mask load after setup");
    wr_m(2'd1, 8'h00);

    // R3/R7 single edge request
    m_irq[3] = 1'b1;
    wait_cyc(2);
    chk_int(1'b1, "R5 int on single request");
    rd_m(2'd0, 8'h08, "R9 default read is request register");
    do_ack(8'h0B, 1'b0, "R3 base 08 line 3");
    chk_int(1'b0, "R7 held edge input does not re-request");
    wr_m(2'd0, 8'h0B);
    rd_m(2'd0, 8'h08, "R9 in-service read after 0x0B");
    wr_m(2'd0, 8'h20);
    rd_m(2'd0, 8'h00, "R8 end-of-service clears line 3");
    m_irq[3] = 1'b0;

    // R4/R5 priority and nesting
    m_irq[5] = 1'b1; m_irq[2] = 1'b1;
    wait_cyc(2);
    do_ack(8'h0A, 1'b0, "R4 line 2 beats line 5");
    chk_int(1'b0, "R5 lower line blocked by in-service line 2");
    m_irq[1] = 1'b1;
    wait_cyc(2);
    chk_int(1'b1, "R5 higher line nests over line 2");
    do_ack(8'h09, 1'b0, "R4 nested line 1");
    rd_m(2'd0, 8'h06, "R4 two lines in service");
    wr_m(2'd0, 8'h20);
    rd_m(2'd0, 8'h04, "R8 clears highest-priority line first");
    wr_m(2'd0, 8'h20);
    chk_int(1'b1, "R5 line 5 released after both retired");
    do_ack(8'h0D, 1'b0, "R4 line 5 served last");
    wr_m(2'd0, 8'h20);
    m_irq = 8'h00;

    // R6 masking keeps the request
    wr_m(2'd0, 8'h0A);
    wr_m(2'd1, 8'h10);
    m_irq[4] = 1'b1;
    wait_cyc(2);
    chk_int(1'b0, "R6 masked line gives no int");
    rd_m(2'd0, 8'h10, "R6 masked request still latched");
    wr_m(2'd1, 8'h00);
    chk_int(1'b1, "R6 unmasked line raises int");
    do_ack(8'h0C, 1'b0, "R6 vector after unmask");
    wr_m(2'd0, 8'h20);
    m_irq[4] = 1'b0;

    // R7 level mode and R10 spurious
    wr_m(2'd2, 8'h40);
    rd_m(2'd2, 8'h40, "R7 trigger register readback");
    m_irq[6] = 1'b1;
    wait_cyc(2);
    chk_int(1'b1, "R7 level request raised");
    m_irq[6] = 1'b0;
    wait_cyc(2);
    chk_int(1'b0, "R7 level request follows input low");
    m_irq[6] = 1'b1;
    wait_cyc(2);
    m_irq[6] = 1'b0;
    do_ack(8'h0F, 1'b0, "R10 spurious vector");
    wr_m(2'd0, 8'h0B);
    rd_m(2'd0, 8'h00, "R10 spurious leaves in-service empty");
    m_irq[6] = 1'b1;
    wait_cyc(2);
    do_ack(8'h0E, 1'b0, "R7 level line vector");
    chk_int(1'b0, "R5 level line blocked while in service");
    wr_m(2'd0, 8'h20);
    chk_int(1'b1, "R7 level line still asserted after retire");
    do_ack(8'h0E, 1'b0, "R7 level line served again");
    m_irq[6] = 1'b0;
    wr_m(2'd0, 8'h20);
    rd_m(2'd0, 8'h00, "R8 in-service empty after level tests");
    wr_m(2'd2, 8'h00);

    // R11 setup-start clears state; R2 without mode word
    wr_m(2'd1, 8'h01);
    m_irq[0] = 1'b1; m_irq[1] = 1'b1;
    wait_cyc(2);
    do_ack(8'h09, 1'b0, "R6 masked line 0 skipped");
    rd_m(2'd0, 8'h02, "R11 in-service before restart");
    wr_m(2'd0, 8'h10);
    rd_m(2'd1, 8'h00, "R11 mask cleared by restart");
    rd_m(2'd0, 8'h00, "R11 edge requests cleared and read select reset");
    wr_m(2'd1, 8'h40);
    wr_m(2'd1, 8'h00);
    wr_m(2'd0, 8'h0B);
    rd_m(2'd0, 8'h00, "R11 in-service cleared by restart");
    wr_m(2'd1, 8'h5A);
    rd_m(2'd1, 8'h5A, "R2 mode word skipped when not requested");
    wr_m(2'd1, 8'h00);
    chk_int(1'b0, "R11 cleared edge not re-raised by held input");
    m_irq = 8'h00;
    wait_cyc(2);
    m_irq[1] = 1'b1;
    wait_cyc(2);
    do_ack(8'h41, 1'b0, "R3 base 40 line 1");
    wr_m(2'd0, 8'h20);
    m_irq = 8'h00;

    // R12/R13 cascade
    wr_m(2'd0, 8'h11);
    wr_m(2'd1, 8'h00);
    wr_m(2'd1, 8'h04);
    wr_m(2'd1, 8'h01);
    wr_m(2'd1, 8'h00);
    wr_s(2'd0, 8'h11);
    wr_s(2'd1, 8'h08);
    wr_s(2'd1, 8'h02);
    wr_s(2'd1, 8'h01);
    wr_s(2'd1, 8'h00);
    cascade_on = 1'b1;
    wait_cyc(2);
    s_irq[5] = 1'b1;
    m_irq[0] = 1'b1;
    wait_cyc(6);
    chk_int(1'b1, "R12 master sees requests");
    do_ack(8'h00, 1'b0, "R13 master-local line 0 vector");
    chk({7'd0, s_int}, 8'h01, "R13 slave still requesting after foreign ack");
    wr_s(2'd0, 8'h0B);
    rd_s(2'd0, 8'h00, "R13 slave ignored foreign ack");
    wr_m(2'd0, 8'h20);
    chk_int(1'b1, "R12 slave line pending at master");
    do_ack(8'h0D, 1'b1, "R12 slave supplies vector");
    wr_m(2'd0, 8'h0B);
    rd_m(2'd0, 8'h04, "R12 master marks cascade line in service");
    rd_s(2'd0, 8'h20, "R13 slave marks its line in service");
    wr_s(2'd0, 8'h20);
    wr_m(2'd0, 8'h20);
    rd_s(2'd0, 8'h00, "R8 slave retired");
    rd_m(2'd0, 8'h00, "R8 master retired");
    s_irq = 8'h00; m_irq = 8'h00;
    wait_cyc(3);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: missing vectors got %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule